// File: doc/BRIEF.md
# Open-Drain Two-Wire Byte Master

This block is a byte-level master for a two-wire serial bus (I2C). Both bus lines are open-drain. For each line the block has a low-drive enable output and a raw input that it reads back from the pad. A host unit sends one command at a time through a valid/ready handshake. The command can place a START condition, shift out a byte and report the acknowledge bit, shift in a byte and acknowledge it, shift in a final byte and close the transfer, or place a STOP condition. Each command returns a one-cycle response carrying the received byte, a not-acknowledged flag and a clock-stuck flag.

Every timing interval is a parameter counted in system clock cycles:

- the setup delay before each clock edge;
- the minimum clock-low time;
- the START hold time;
- the bus-free time after STOP;
- the clock poll period and the number of polls.

After each clock release the block waits until it reads the clock line high again, so a slave that stretches the clock is honoured. If the line never reads high within the poll budget, the block raises the stuck flag and carries on with the command. Both inputs pass through a two-flop synchronizer before they are used.

Top module: `i2c_byte_master`

## Requirements
- R1: Out of reset, cmd_ready_o is 1, rsp_valid_o is 0, and both drive enables are 0, so both lines are released. A line is only ever pulled low or released, never driven high.
- R2: Opcode 0 (START) releases SDA, then releases SCL and waits for it to read high, then pulls SDA low while SCL is high. After the hold time it pulls SCL low. The command ends with both enables at 1.
- R3: Opcode 1 (WRITE) shifts cmd_data_i out MSB first. SDA changes only while SCL is held low. On the ninth clock pulse SDA is released and sampled: rsp_nack_o is 1 when SDA reads high and 0 when it reads low.
- R4: Opcode 2 (READ_ACK) samples eight bits MSB first while SCL is high and returns them on rsp_data_o. It holds SDA low through the ninth clock pulse and ends with SDA released and SCL low.
- R5: Opcode 3 (READ_LAST) reads the byte in the same way but leaves SDA released on the ninth pulse. It then performs a full STOP, so it ends with both lines released.
- R6: Opcode 4 (STOP) pulls SCL low, pulls SDA low, releases SCL, then releases SDA while SCL is high. No response and no new START follow within BUF_CYC cycles of that SDA rise.
- R7: After each SCL release, SCL is not pulled low again until the synchronized SCL input has read high or the poll budget has run out. A slave that holds SCL low within the budget therefore only delays the transfer.
- R8: When SCL stays low for POLL_STEPS polls of POLL_CYC cycles, the command still completes and its response has rsp_stuck_o = 1. The flag is cleared when the next command is accepted.
- R9: Every SCL low phase driven by the block lasts at least LOW_CYC cycles.
- R10: A command is accepted only while cmd_ready_o is 1, and ready falls in the cycle after acceptance. Each accepted command gives exactly one rsp_valid_o pulse. Opcodes 5 to 7 complete without any line activity and with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle and able to take a command |
| cmd_op_i | input | 3 | Opcode: 0 START, 1 WRITE, 2 READ_ACK, 3 READ_LAST, 4 STOP |
| cmd_data_i | input | 8 | Byte to send for WRITE |
| rsp_valid_o | output | 1 | One-cycle pulse when a command completes |
| rsp_data_o | output | 8 | Byte received by a read |
| rsp_nack_o | output | 1 | Slave did not acknowledge the written byte |
| rsp_stuck_o | output | 1 | SCL stayed low past the poll budget during the command |
| scl_i | input | 1 | SCL pad input |
| scl_oe_o | output | 1 | SCL low-drive enable |
| sda_i | input | 1 | SDA pad input |
| sda_oe_o | output | 1 | SDA low-drive enable |

## Verification
The bench builds the block with a setup delay of 2 cycles, a low time of 3, a hold time of 2, a poll period of 3, four polls and a bus-free time of 12 cycles. With these values one byte takes about 130 cycles. That is short enough to sweep all 256 written bytes and all 256 read bytes against a slave model in the bench. The stuck-clock timeout fires after about a dozen cycles, so it can be reached directly. A 14-cycle stretch lands inside the poll budget, which separates the case where a stretch is honoured from the case where it times out. The bench measures the bus-free interval after STOP and the shortest clock-low phase from the line transitions.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [2:0] {
    OPC_START   = 3'd0,
    OPC_WRITE   = 3'd1,
    OPC_RD_ACK  = 3'd2,
    OPC_RD_LAST = 3'd3,
    OPC_STOP    = 3'd4
  } opc_e;

  // bit-level operations the sequencer hands to the line driver
  typedef enum logic [2:0] {
    BOP_SCL_LO,
    BOP_SCL_HI,
    BOP_SDA,
    BOP_HOLD,
    BOP_BUF
  } bop_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_eng_sync.sv
module i2c_eng_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= 1'b1;
        ff2_q <= 1'b1;
      end else begin
        ff1_q <= d_i[g];
        ff2_q <= ff1_q;
      end
    end
    assign q_o[g] = ff2_q;
  end

endmodule

// File: rtl/i2c_eng_phy.sv
module i2c_eng_phy
  import i2c_eng_pkg::*;
#(
  parameter int SETUP_CYC  = 125,
  parameter int LOW_CYC    = 250,
  parameter int HOLD_CYC   = 125,
  parameter int BUF_CYC    = 7500,
  parameter int POLL_CYC   = 250,
  parameter int POLL_STEPS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_req_i,
  input  bop_e op_i,
  input  logic op_val_i,
  input  logic scl_s_i,
  output logic op_done_o,
  output logic op_stuck_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);

  localparam int CNT_MAX = imax(imax(imax(SETUP_CYC, LOW_CYC), imax(HOLD_CYC, BUF_CYC)), POLL_CYC);
  localparam int TW = $clog2(CNT_MAX + 1);
  localparam int SW = $clog2(POLL_STEPS + 1);
  localparam logic [TW-1:0] SETUP_T = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LOW_T   = TW'(LOW_CYC - 1);
  localparam logic [TW-1:0] HOLD_T  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] BUF_T   = TW'(BUF_CYC - 1);
  localparam logic [TW-1:0] POLL_T  = TW'(POLL_CYC - 1);
  localparam logic [SW-1:0] STEPS_T = SW'(POLL_STEPS - 1);
  localparam logic [TW-1:0] LOW_MIN = TW'(LOW_CYC);

  typedef enum logic [1:0] {X_IDLE, X_PRE, X_POST, X_POLL} ph_e;

  ph_e            ph_q;
  bop_e           op_q;
  logic [TW-1:0]  tmr_q;
  logic [SW-1:0]  steps_q;
  logic           scl_oe_q, sda_oe_q;
  logic           tmr_zero, poll_end;

  assign tmr_zero   = (tmr_q == '0);
  assign poll_end   = (ph_q == X_POLL) && tmr_zero && (scl_s_i || steps_q == '0);
  assign op_done_o  = ((ph_q == X_POST) && tmr_zero) || poll_end;
  assign op_stuck_o = poll_end && !scl_s_i;
  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= X_IDLE;
      op_q     <= BOP_HOLD;
      tmr_q    <= '0;
      steps_q  <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (ph_q)
        X_IDLE: if (op_req_i) begin
          op_q <= op_i;
          unique case (op_i)
            BOP_SCL_LO, BOP_SCL_HI: begin ph_q <= X_PRE;  tmr_q <= SETUP_T; end
            BOP_SDA:  begin sda_oe_q <= !op_val_i; ph_q <= X_POST; tmr_q <= LOW_T; end
            BOP_HOLD: begin ph_q <= X_POST; tmr_q <= HOLD_T; end
            default:  begin ph_q <= X_POST; tmr_q <= BUF_T; end
          endcase
        end
        X_PRE: if (tmr_zero) begin
          if (op_q == BOP_SCL_LO) begin
            scl_oe_q <= 1'b1;
            ph_q     <= X_POST;
            tmr_q    <= LOW_T;
          end else begin
            scl_oe_q <= 1'b0;
            ph_q     <= X_POLL;
            tmr_q    <= POLL_T;
            steps_q  <= STEPS_T;
          end
        end else tmr_q <= tmr_q - 1'b1;
        X_POST: if (tmr_zero) ph_q <= X_IDLE;
                else tmr_q <= tmr_q - 1'b1;
        default: if (tmr_zero) begin
          if (poll_end) ph_q <= X_IDLE;
          else begin
            steps_q <= steps_q - 1'b1;
            tmr_q   <= POLL_T;
          end
        end else tmr_q <= tmr_q - 1'b1;
      endcase
    end
  end

  // observation state for the line-timing properties
  logic [TW-1:0] lo_cnt_q;
  logic          seen_hi_q, tmo_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q  <= '0;
      seen_hi_q <= 1'b1;
      tmo_q     <= 1'b0;
    end else begin
      if (!scl_oe_q) lo_cnt_q <= '0;
      else if (lo_cnt_q < LOW_MIN) lo_cnt_q <= lo_cnt_q + 1'b1;
      if (scl_oe_q) seen_hi_q <= 1'b0;
      else if (scl_s_i) seen_hi_q <= 1'b1;
      if (scl_oe_q) tmo_q <= 1'b0;
      else if (op_stuck_o) tmo_q <= 1'b1;
    end
  end

  AST_SCL_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_q) |-> lo_cnt_q >= LOW_MIN); // R9
  AST_STRETCH_HONORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_q) |-> (seen_hi_q || tmo_q)); // R7
  AST_STUCK_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_stuck_o |-> op_done_o && !scl_oe_q); // R8

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_eng_pkg::*;
#(
  parameter int SETUP_CYC  = 125,
  parameter int LOW_CYC    = 250,
  parameter int HOLD_CYC   = 125,
  parameter int BUF_CYC    = 7500,
  parameter int POLL_CYC   = 250,
  parameter int POLL_STEPS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [2:0] cmd_op_i,
  input  logic [7:0] cmd_data_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       rsp_nack_o,
  output logic       rsp_stuck_o,
  input  logic       scl_i,
  output logic       scl_oe_o,
  input  logic       sda_i,
  output logic       sda_oe_o
);

  localparam int FW = $clog2(BUF_CYC + 1);
  localparam logic [FW-1:0] BUF_F = FW'(BUF_CYC);

  typedef enum logic [4:0] {
    Q_IDLE, Q_RESP,
    Q_ST_REL, Q_ST_SCLH, Q_ST_SDAL, Q_ST_HOLD, Q_ST_SCLL,
    Q_WB_SDA, Q_WB_SCLH, Q_WB_SCLL,
    Q_WA_REL, Q_WA_SCLH, Q_WA_SCLL,
    Q_RB_REL, Q_RB_SCLH, Q_RB_SCLL,
    Q_RA_SDAL, Q_RA_SCLH, Q_RA_SCLL, Q_RA_REL,
    Q_RL_SCLH,
    Q_SP_SCLL, Q_SP_SDAL, Q_SP_SCLH, Q_SP_REL, Q_SP_BUF
  } st_e;

  st_e        state_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;
  logic       nack_q, stuck_q, last_q;
  logic       scl_s, sda_s;
  logic       op_req, op_val, op_done, op_stuck;
  bop_e       op;

  i2c_eng_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_eng_phy #(
    .SETUP_CYC (SETUP_CYC),
    .LOW_CYC   (LOW_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .BUF_CYC   (BUF_CYC),
    .POLL_CYC  (POLL_CYC),
    .POLL_STEPS(POLL_STEPS)
  ) u_phy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_req_i  (op_req),
    .op_i      (op),
    .op_val_i  (op_val),
    .scl_s_i   (scl_s),
    .op_done_o (op_done),
    .op_stuck_o(op_stuck),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o)
  );

  always_comb begin
    op_req = 1'b1;
    op_val = 1'b1;
    op     = BOP_SDA;
    unique case (state_q)
      Q_IDLE, Q_RESP: op_req = 1'b0;
      Q_ST_SCLH, Q_WB_SCLH, Q_WA_SCLH, Q_RB_SCLH,
      Q_RA_SCLH, Q_RL_SCLH, Q_SP_SCLH:          op = BOP_SCL_HI;
      Q_ST_SCLL, Q_WB_SCLL, Q_WA_SCLL, Q_RB_SCLL,
      Q_RA_SCLL, Q_SP_SCLL:                      op = BOP_SCL_LO;
      Q_ST_HOLD:                                 op = BOP_HOLD;
      Q_SP_BUF:                                  op = BOP_BUF;
      Q_ST_SDAL, Q_RA_SDAL, Q_SP_SDAL:           op_val = 1'b0;
      Q_WB_SDA:                                  op_val = sh_q[7];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= Q_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      nack_q  <= 1'b0;
      stuck_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (op_stuck) stuck_q <= 1'b1;
      unique case (state_q)
        Q_IDLE: if (cmd_valid_i) begin
          nack_q  <= 1'b0;
          stuck_q <= 1'b0;
          bit_q   <= '0;
          last_q  <= (cmd_op_i == OPC_RD_LAST);
          sh_q    <= (cmd_op_i == OPC_WRITE) ? cmd_data_i : 8'h00;
          unique case (cmd_op_i)
            OPC_START:              state_q <= Q_ST_REL;
            OPC_WRITE:              state_q <= Q_WB_SDA;
            OPC_RD_ACK, OPC_RD_LAST: state_q <= Q_RB_REL;
            OPC_STOP:               state_q <= Q_SP_SCLL;
            default:                state_q <= Q_RESP;
          endcase
        end
        Q_RESP: state_q <= Q_IDLE;
        default: if (op_done) begin
          unique case (state_q)
            Q_ST_REL:  state_q <= Q_ST_SCLH;
            Q_ST_SCLH: state_q <= Q_ST_SDAL;
            Q_ST_SDAL: state_q <= Q_ST_HOLD;
            Q_ST_HOLD: state_q <= Q_ST_SCLL;
            Q_WB_SDA:  state_q <= Q_WB_SCLH;
            Q_WB_SCLH: state_q <= Q_WB_SCLL;
            Q_WB_SCLL: begin
              sh_q <= {sh_q[6:0], 1'b0};
              bit_q <= bit_q + 1'b1;
              state_q <= (bit_q == 3'd7) ? Q_WA_REL : Q_WB_SDA;
            end
            Q_WA_REL:  state_q <= Q_WA_SCLH;
            Q_WA_SCLH: begin nack_q <= sda_s; state_q <= Q_WA_SCLL; end
            Q_RB_REL:  state_q <= Q_RB_SCLH;
            Q_RB_SCLH: begin sh_q <= {sh_q[6:0], sda_s}; state_q <= Q_RB_SCLL; end
            Q_RB_SCLL: begin
              bit_q <= bit_q + 1'b1;
              if (bit_q != 3'd7) state_q <= Q_RB_SCLH;
              else state_q <= last_q ? Q_RL_SCLH : Q_RA_SDAL;
            end
            Q_RA_SDAL: state_q <= Q_RA_SCLH;
            Q_RA_SCLH: state_q <= Q_RA_SCLL;
            Q_RA_SCLL: state_q <= Q_RA_REL;
            Q_RL_SCLH: state_q <= Q_SP_SCLL;
            Q_SP_SCLL: state_q <= Q_SP_SDAL;
            Q_SP_SDAL: state_q <= Q_SP_SCLH;
            Q_SP_SCLH: state_q <= Q_SP_REL;
            Q_SP_REL:  state_q <= Q_SP_BUF;
            default:   state_q <= Q_RESP;  // ST_SCLL, WA_SCLL, RA_REL, SP_BUF
          endcase
        end
      endcase
    end
  end

  assign cmd_ready_o = (state_q == Q_IDLE);
  assign rsp_valid_o = (state_q == Q_RESP);
  assign rsp_data_o  = sh_q;
  assign rsp_nack_o  = nack_q;
  assign rsp_stuck_o = stuck_q;

  // cycles since SDA was last released with SCL released (stop condition)
  logic [FW-1:0] free_cnt_q;
  logic          sda_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_cnt_q <= BUF_F;
      sda_prev_q <= 1'b0;
    end else begin
      sda_prev_q <= sda_oe_o;
      if (sda_prev_q && !sda_oe_o && !scl_oe_o) free_cnt_q <= '0;
      else if (free_cnt_q < BUF_F) free_cnt_q <= free_cnt_q + 1'b1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o); // R10
  AST_SINGLE_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && cmd_ready_o); // R10
  AST_SDA_HELD_HIGH_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == Q_WB_SCLH) && $past(state_q == Q_WB_SCLH) |-> $stable(sda_oe_o)); // R3
  AST_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) && !scl_oe_o |-> free_cnt_q >= BUF_F); // R6

endmodule

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;

  localparam int SETUP_P = 2, LOW_P = 3, HOLD_P = 2, BUF_P = 12, POLL_P = 3, STEPS_P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, rsp_valid, rsp_nack, rsp_stuck, scl_oe, sda_oe;
  logic [7:0] rsp_data;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // bus and slave model
  logic sl_hold = 1'b0, stuck_hold = 1'b0, sl_sda_low;
  logic [1:0] mode = 2'd0;
  logic ack_en = 1'b0, mack = 1'b0;
  logic [7:0] rd_val = 8'h00, cap = 8'h00;
  int rcnt = 0, fcnt = 0, rbase = 0, fbase = 0, stretch = 0;
  int starts = 0, stops = 0, stop_cyc = 0, tcnt = 0, tfall = 0, low_min = 1000000;
  logic scl_line, sda_line;

  assign scl_line = !(scl_oe | sl_hold | stuck_hold);
  always_comb begin
    int fr;
    fr = fcnt - fbase;
    sl_sda_low = 1'b0;
    if (mode == 2'd2 && fr >= 0 && fr < 8) sl_sda_low = !rd_val[7 - fr];
    else if (mode == 2'd1 && fr == 8) sl_sda_low = ack_en;
  end
  assign sda_line = !(sda_oe | sl_sda_low);

  always @(posedge scl_line) begin
    int rr;
    rr = rcnt - rbase;
    if (mode == 2'd1 && rr < 8) cap = {cap[6:0], sda_line};
    if (mode == 2'd2 && rr == 8) mack = !sda_line;
    rcnt++;
    if (cyc > 5 && cyc - tfall < low_min) low_min = cyc - tfall;
  end
  always @(negedge scl_line) begin
    fcnt++;
    tfall = cyc;
    if (stretch > 0) begin
      sl_hold = 1'b1;
      repeat (stretch) @(posedge clk);
      sl_hold = 1'b0;
    end
  end
  always @(negedge sda_line) if (scl_line === 1'b1) starts++;
  always @(posedge sda_line) if (scl_line === 1'b1) begin stops++; stop_cyc = cyc; end
  always @(scl_line or sda_line) tcnt++;

  i2c_byte_master #(
    .SETUP_CYC(SETUP_P), .LOW_CYC(LOW_P), .HOLD_CYC(HOLD_P),
    .BUF_CYC(BUF_P), .POLL_CYC(POLL_P), .POLL_STEPS(STEPS_P)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_nack_o(rsp_nack), .rsp_stuck_o(rsp_stuck),
    .scl_i(scl_line), .scl_oe_o(scl_oe),
    .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int   acc_cyc, rsp_cyc;
  logic [7:0] r_data;
  logic r_nack, r_stuck;

  task automatic arm(input logic [1:0] m);
    mode  = m;
    rbase = rcnt;
    fbase = fcnt;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] d);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    acc_cyc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    chk(rsp_valid, "R10 response arrives", int'(rsp_valid), 1);
    rsp_cyc = cyc; r_data = rsp_data; r_nack = rsp_nack; r_stuck = rsp_stuck;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t0, s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp idle in reset", int'(rsp_valid), 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !scl_oe && !sda_oe, "R1 idle after reset", int'({cmd_ready, scl_oe, sda_oe}), 4);

    // R2 START
    s0 = starts;
    arm(2'd0);
    run_cmd(3'd0, 8'h00);
    chk(starts == s0 + 1, "R2 start condition seen", starts - s0, 1);
    chk(scl_oe && sda_oe, "R2 both held low after start", int'({scl_oe, sda_oe}), 3);

    // R3 write sweep of all bytes, ack pattern from the byte itself
    for (int v = 0; v < 256; v++) begin
      ack_en = v[0] ^ v[3];
      arm(2'd1);
      run_cmd(3'd1, 8'(v));
      chk(cap == 8'(v), "R3 byte on bus", int'(cap), v);
      chk(r_nack == !ack_en, "R3 nack flag", int'(r_nack), int'(!ack_en));
    end

    // R7 clock stretch inside the poll budget
    stretch = 14; ack_en = 1'b1;
    arm(2'd1);
    run_cmd(3'd1, 8'h3C);
    stretch = 0;
    chk(cap == 8'h3C, "R7 byte survives stretch", int'(cap), 8'h3C);
    chk(r_nack == 1'b0, "R7 ack survives stretch", int'(r_nack), 0);
    chk(r_stuck == 1'b0, "R7 no stuck on stretch", int'(r_stuck), 0);
    repeat (30) @(negedge clk);

    // R4 read sweep with master acknowledge
    for (int v = 0; v < 256; v++) begin
      rd_val = 8'(v ^ 8'h5A);
      mack = 1'b0;
      arm(2'd2);
      run_cmd(3'd2, 8'h00);
      chk(r_data == rd_val, "R4 read byte", int'(r_data), int'(rd_val));
      chk(mack == 1'b1, "R4 master ack on ninth pulse", int'(mack), 1);
      chk(!sda_oe && scl_oe, "R4 sda released scl low at end", int'({scl_oe, sda_oe}), 2);
    end

    // R5 last read: no ack, then stop
    for (int k = 0; k < 3; k++) begin
      arm(2'd0);
      run_cmd(3'd0, 8'h00);
      rd_val = (k == 0) ? 8'h00 : (k == 1) ? 8'hC3 : 8'hFF;
      mack = 1'b1;
      s0 = stops;
      arm(2'd2);
      run_cmd(3'd3, 8'h00);
      chk(r_data == rd_val, "R5 last byte", int'(r_data), int'(rd_val));
      chk(mack == 1'b0, "R5 no ack on last byte", int'(mack), 0);
      chk(stops == s0 + 1, "R5 stop follows", stops - s0, 1);
      chk(!scl_oe && !sda_oe, "R5 bus released", int'({scl_oe, sda_oe}), 0);
    end

    // R6 stop and bus-free time
    arm(2'd0);
    run_cmd(3'd0, 8'h00);
    ack_en = 1'b1;
    arm(2'd1);
    run_cmd(3'd1, 8'hA0);
    s0 = stops;
    arm(2'd0);
    run_cmd(3'd4, 8'h00);
    chk(stops == s0 + 1, "R6 stop condition seen", stops - s0, 1);
    chk(rsp_cyc - stop_cyc >= BUF_P, "R6 bus free before response", rsp_cyc - stop_cyc, BUF_P);
    chk(!scl_oe && !sda_oe, "R6 bus released", int'({scl_oe, sda_oe}), 0);

    // R8 clock held low forever
    arm(2'd0);
    run_cmd(3'd0, 8'h00);
    stuck_hold = 1'b1;
    arm(2'd0);
    run_cmd(3'd1, 8'h81);
    chk(r_stuck == 1'b1, "R8 stuck flag set", int'(r_stuck), 1);
    chk(r_nack == 1'b1, "R8 released sda reads nack", int'(r_nack), 1);
    stuck_hold = 1'b0;
    repeat (5) @(negedge clk);
    run_cmd(3'd4, 8'h00);
    chk(r_stuck == 1'b0, "R8 flag cleared on next command", int'(r_stuck), 0);

    // R10 undefined opcode
    t0 = tcnt;
    run_cmd(3'd7, 8'hFF);
    chk(rsp_cyc - acc_cyc <= 3, "R10 undefined op completes fast", rsp_cyc - acc_cyc, 2);
    chk(tcnt == t0, "R10 no line activity", tcnt - t0, 0);
    chk(!r_nack && !r_stuck, "R10 flags clear", int'({r_nack, r_stuck}), 0);
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R10 single pulse", int'({cmd_ready, rsp_valid}), 2);

    // R9 shortest clock-low phase seen on the bus
    chk(low_min >= LOW_P, "R9 minimum scl low", low_min, LOW_P);

    summary();
    $finish;
  end

endmodule